// File: doc/BRIEF.md
# Three-Weight Accumulator Pattern Generator

This block produces self-test stimulus from an accumulator. On every active step the pattern register takes its previous value plus a constant addend. The addition wraps modulo 2^WIDTH over the bits that are free to count. Each bit can carry one of three weights:

- weight 1: the bit is forced high.
- weight 0: the bit is forced low.
- weight one half: the bit accumulates normally.

A forced bit does not break the carry chain. Its adder cell gets operands that are complements of each other, so the carry leaving the cell equals the carry entering it. The free bits therefore behave as one compacted counter.

The adder is split into blocks of BLK bits. Each block computes its sum and carry twice, once for carry-in 0 and once for carry-in 1. The true block carry then selects the result through multiplexers.

A two-state controller governs stepping. The states are:

- ST_IDLE: the register holds.
- ST_RUN: the register steps on every clock while enable is high.

The transitions are:

- IDLE→RUN when enable is high.
- RUN→IDLE when enable is low.
- Any state→IDLE on synchronous reset.

Reset also loads the register with the seed input. Because the first cycle with enable high only moves the controller into ST_RUN, the first new pattern appears one clock after that.

Top module: `tri_weight_patgen`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, `pattern_o` becomes `seed_i` and the controller enters ST_IDLE.
- R2: In ST_IDLE, a clock edge with `enable_i` high moves the controller to ST_RUN and leaves `pattern_o` unchanged.
- R3: In ST_RUN with `enable_i` high and both masks zero, each clock edge sets `pattern_o` to (previous `pattern_o` + `addend_i`) mod 2^WIDTH.
- R4: A clock edge with `enable_i` low leaves `pattern_o` unchanged and leaves the controller in (or returns it to) ST_IDLE.
- R5: After a stepping edge, every bit i with `force0_i[i]`=1 reads 0.
- R6: After a stepping edge, every bit i with `force1_i[i]`=1 and `force0_i[i]`=0 reads 1.
- R7: When both masks are set for the same bit, that bit reads 0, because the force-low mask wins.
- R8: Forced bits pass the carry through unchanged. The free bits, taken in ascending order, step as one counter: they add the free bits of `addend_i` and discard the carry out of the highest free bit.
- R9: With `addend_i` zero, stepping edges keep the free bits constant, so the block yields a single pattern.
- R10: With both masks zero and an odd addend, the pattern returns to its starting value after exactly 2^WIDTH stepping edges and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous active-high reset; loads the seed |
| enable_i | input | 1 | Start/step enable |
| seed_i | input | WIDTH | Value loaded on reset |
| addend_i | input | WIDTH | Constant addend |
| force1_i | input | WIDTH | Per-bit force-high mask (weight 1) |
| force0_i | input | WIDTH | Per-bit force-low mask (weight 0); wins over force1_i |
| pattern_o | output | WIDTH | Current test pattern |

## Verification
The bench builds the block with WIDTH=8 and BLK=4. This makes two carry-select blocks, so the select path across the block boundary is exercised. It also keeps the full 256-step period short enough to walk every state and confirm the exact return point. Mask values are chosen so that forced bits sit in both blocks and at the block edge. This covers the carry pass-through, including the case where it crosses from one block into the next.

// File: rtl/tw_pkg.sv
package tw_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tw_state_e;
endpackage

// File: rtl/tw_cell.sv
// One accumulator bit: full adder whose A operand is replaced by NOT B when
// the bit has a fixed weight, so the carry leaves exactly as it arrived.
module tw_cell (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    input  logic fixed_i,
    output logic s_o,
    output logic c_o
);
    logic a_eff;
    assign a_eff = fixed_i ? ~b_i : a_i;
    assign s_o   = a_eff ^ b_i ^ c_i;
    assign c_o   = (a_eff & b_i) | (c_i & (a_eff ^ b_i));
endmodule

// File: rtl/tw_block.sv
// Carry-select block: two ripple lanes, one assuming carry-in 0, one assuming 1.
module tw_block #(
    parameter int BW = 4
) (
    input  logic [BW-1:0] a_i,
    input  logic [BW-1:0] b_i,
    input  logic [BW-1:0] fixed_i,
    output logic [BW-1:0] s0_o,
    output logic [BW-1:0] s1_o,
    output logic          c0_o,
    output logic          c1_o
);
    logic [BW:0] ch0;
    logic [BW:0] ch1;

    assign ch0[0] = 1'b0;
    assign ch1[0] = 1'b1;

    for (genvar i = 0; i < BW; i++) begin : g_bit
        tw_cell u_lane0 (
            .a_i    (a_i[i]),
            .b_i    (b_i[i]),
            .c_i    (ch0[i]),
            .fixed_i(fixed_i[i]),
            .s_o    (s0_o[i]),
            .c_o    (ch0[i+1])
        );
        tw_cell u_lane1 (
            .a_i    (a_i[i]),
            .b_i    (b_i[i]),
            .c_i    (ch1[i]),
            .fixed_i(fixed_i[i]),
            .s_o    (s1_o[i]),
            .c_o    (ch1[i+1])
        );
    end

    assign c0_o = ch0[BW];
    assign c1_o = ch1[BW];
endmodule

// File: rtl/tri_weight_patgen.sv
module tri_weight_patgen #(
    parameter int WIDTH = 8,
    parameter int BLK   = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             enable_i,
    input  logic [WIDTH-1:0] seed_i,
    input  logic [WIDTH-1:0] addend_i,
    input  logic [WIDTH-1:0] force1_i,
    input  logic [WIDTH-1:0] force0_i,
    output logic [WIDTH-1:0] pattern_o
);
    import tw_pkg::*;

    localparam int NBLK = WIDTH / BLK;

    tw_state_e        state_q, state_d;
    logic [WIDTH-1:0] pat_q;
    logic [WIDTH-1:0] fixed_w;
    logic [WIDTH-1:0] sum_w;
    logic [WIDTH-1:0] next_w;
    logic [NBLK:0]    blk_carry;
    logic             step_w;

    assign fixed_w      = force0_i | force1_i;
    assign blk_carry[0] = 1'b0;

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        logic [BLK-1:0] s0, s1;
        logic           c0, c1;
        tw_block #(.BW(BLK)) u_blk (
            .a_i    (pat_q[b*BLK +: BLK]),
            .b_i    (addend_i[b*BLK +: BLK]),
            .fixed_i(fixed_w[b*BLK +: BLK]),
            .s0_o   (s0),
            .s1_o   (s1),
            .c0_o   (c0),
            .c1_o   (c1)
        );
        assign sum_w[b*BLK +: BLK] = blk_carry[b] ? s1 : s0;
        assign blk_carry[b+1]      = blk_carry[b] ? c1 : c0;
    end

    // weight override: force-low has priority over force-high
    assign next_w = (sum_w | force1_i) & ~force0_i;

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (enable_i)  state_d = ST_RUN;
            ST_RUN:  if (!enable_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // output process: the pattern register
    always_comb begin
        step_w = 1'b0;
        unique case (state_q)
            ST_IDLE: step_w = 1'b0;
            ST_RUN:  step_w = enable_i;
            default: step_w = 1'b0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)       pat_q <= seed_i;
        else if (step_w) pat_q <= next_w;
    end

    assign pattern_o = pat_q;
endmodule

// File: rtl/tw_patgen_chk.sv
module tw_patgen_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             enable_i,
    input logic [WIDTH-1:0] force1_i,
    input logic [WIDTH-1:0] force0_i,
    input logic [WIDTH-1:0] pattern_o,
    input tw_pkg::tw_state_e state_q
);
    import tw_pkg::*;

    logic stepping;
    assign stepping = (state_q == ST_RUN) && enable_i;

    p_idle_to_run_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_IDLE && enable_i) |=> (state_q == ST_RUN));

    p_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        !stepping |=> $stable(pattern_o));

    p_drop_to_idle_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        !enable_i |=> (state_q == ST_IDLE));

    p_force_low_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        stepping |=> ((pattern_o & $past(force0_i)) == '0));

    p_force_high_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        stepping |=> ((pattern_o & $past(force1_i & ~force0_i))
                      == $past(force1_i & ~force0_i)));
endmodule

bind tri_weight_patgen tw_patgen_chk #(.WIDTH(WIDTH)) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .enable_i (enable_i),
    .force1_i (force1_i),
    .force0_i (force0_i),
    .pattern_o(pattern_o),
    .state_q  (state_q)
);

// File: tb/tri_weight_patgen_tb_top.sv
`timescale 1ns/1ps
module tri_weight_patgen_tb_top;
    localparam int W = 8;
    localparam int B = 4;

    logic         clk = 1'b0;
    logic         rst_i, enable_i;
    logic [W-1:0] seed_i, addend_i, force1_i, force0_i;
    logic [W-1:0] pattern_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // reference state
    logic [W-1:0] m_pat;
    bit           m_run;

    always #4 clk = ~clk;

    tri_weight_patgen #(.WIDTH(W), .BLK(B)) dut_i (
        .clk_i(clk), .rst_i(rst_i), .enable_i(enable_i), .seed_i(seed_i),
        .addend_i(addend_i), .force1_i(force1_i), .force0_i(force0_i),
        .pattern_o(pattern_o)
    );

    // bit-serial model: forced bits skip the carry, free bits add
    function automatic logic [W-1:0] ref_next(logic [W-1:0] p, logic [W-1:0] v,
                                              logic [W-1:0] f0, logic [W-1:0] f1);
        logic [W-1:0] r = '0;
        int c = 0;
        for (int i = 0; i < W; i++) begin
            if (f0[i])      r[i] = 1'b0;
            else if (f1[i]) r[i] = 1'b1;
            else begin
                int s = int'(p[i]) + int'(v[i]) + c;
                r[i] = s[0];
                c    = s / 2;
            end
        end
        return r;
    endfunction

    task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(string tag);
        logic [W-1:0] nxt;
        if (rst_i) begin
            nxt = seed_i; m_run = 1'b0;
        end else begin
            nxt   = (m_run && enable_i) ? ref_next(m_pat, addend_i, force0_i, force1_i) : m_pat;
            m_run = enable_i;
        end
        m_pat = nxt;
        @(posedge clk);
        #1;
        check(tag, pattern_o, m_pat);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got hung expected finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int first_ret;
        rst_i = 1'b1; enable_i = 1'b0; seed_i = 8'hA5; addend_i = 8'h13;
        force1_i = '0; force0_i = '0; m_pat = '0; m_run = 1'b0;
        step("R1 reset loads seed");
        step("R1 reset loads seed");
        rst_i = 1'b0; enable_i = 1'b1;
        step("R2 idle to run holds");
        for (int i = 0; i < 6; i++) step("R3 add addend");
        enable_i = 1'b0;
        for (int i = 0; i < 3; i++) step("R4 hold when disabled");
        enable_i = 1'b1;
        step("R2 restart holds");
        step("R3 step after restart");
        addend_i = 8'h7D; force0_i = 8'h0F;
        for (int i = 0; i < 6; i++) step("R5 force low");
        force0_i = '0; force1_i = 8'hF0;
        for (int i = 0; i < 6; i++) step("R6 force high");
        force0_i = 8'h3C; force1_i = 8'h3C;
        for (int i = 0; i < 6; i++) step("R7 force low wins");
        addend_i = 8'h5B; force1_i = 8'h24; force0_i = 8'h81;
        for (int i = 0; i < 24; i++) step("R8 carry pass-through");
        force1_i = 8'h18; force0_i = 8'h00; addend_i = 8'h01;
        for (int i = 0; i < 12; i++) step("R8 carry crosses block edge");
        addend_i = 8'h00; force1_i = 8'h02; force0_i = '0;
        for (int i = 0; i < 6; i++) step("R9 zero addend");
        // period walk
        rst_i = 1'b1; enable_i = 1'b0; seed_i = 8'h37; addend_i = 8'h35;
        force1_i = '0; force0_i = '0;
        step("R1 reseed");
        rst_i = 1'b0; enable_i = 1'b1;
        step("R2 idle to run");
        first_ret = 0;
        for (int i = 1; i <= 256; i++) begin
            step("R3 period walk");
            if (first_ret == 0 && pattern_o == 8'h37) first_ret = i;
        end
        checks++;
        if (first_ret != 256) begin
            errors++;
            $display("FAIL R10 period: got %0d expected %0d", first_ret, 256);
        end
        check("R10 back at seed", pattern_o, 8'h37);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule